// File: doc/BRIEF.md
# Mailbox Command Sequencer

This block hands a command to a remote processing engine through a shared window of sixteen 32-bit words. A local requester supplies a command code, up to twelve argument words and the number of result words it expects. The sequencer then runs the whole exchange through a single-word access port:

- It fills the window and raises a go flag.
- It polls the flag word until the engine reports completion.
- It collects the result words.
- It parks the window in the idle state again.

A status word that reads back as zero means the engine dropped the exchange. In that case the whole command is issued again, up to a fixed number of attempts. A status word that stays non-zero without ever showing completion means the engine is hung. Exhausted retries, a hung engine and a transport error on the access port all mark the engine as failed. The failed mark is sticky until reset, and every later command is refused at once without touching the window.

Top module: `mbx_cmd_seq`

## Requirements
- R1: After reset `busy`, `done` and `mb_req` are low, `status` is 0 and `engine_ok` is high.
- R2: A request with `send_cnt` or `recv_cnt` above 12 finishes with status 1 (invalid) and makes no window access. This check runs before the engine-failed check.
- R3: An accepted command first writes all 16 window words, in ascending order, to addresses 0x44 to 0x53, as follows:
  - word 0 = 0;
  - word 1 = command code;
  - word 2 = 0;
  - word 3 = 0x00060000;
  - word 4+i = argument i (taken from `args_in` bits 32i+31:32i) for i below `send_cnt`, and 0 for every other argument word.
- R4: After the fill, exactly one write of 0x3 to address 0x44 raises the go flag.
- R5: Each poll reads `recv_cnt`+4 words in ascending order from 0x44. Bit 2 of word 0 set means the engine has completed.
- R6: A non-zero word 0 without bit 2 triggers another poll, for at most 1000 polls per attempt. After that the command ends with status 3 (timeout) and `engine_ok` goes low.
- R7: A zero word 0 restarts the whole command from the fill phase. After 20 attempts in total the command ends with status 3 and `engine_ok` goes low.
- R8: On completion, word 4+i of the last poll appears on `results` bits 32i+31:32i for i below `recv_cnt`, and the other result words are 0. Then 0 is written to 0x44 and the command ends with status 0.
- R9: An access acknowledged with `mb_err` aborts the command at once with status 2 (I/O error) and drops `engine_ok`. `engine_ok` stays low until reset.
- R10: While `engine_ok` is low, a valid request ends with status 2 and no window access.
- R11: `busy` is high from acceptance until the completing cycle. A `start` seen while busy is ignored. A `start` in the cycle that `done` pulses is accepted.
- R12: `done` is a one-cycle pulse. `status` and `results` hold until the next `start` is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a command (sampled when idle) |
| cmd_code | input | 32 | Command code placed in window word 1 |
| send_cnt | input | 4 | Number of argument words to send |
| recv_cnt | input | 4 | Number of result words to collect |
| args_in | input | 384 | Argument words, word i at bits 32i+31:32i |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 ok, 1 invalid, 2 I/O error or refused, 3 timeout |
| results | output | 384 | Result words, word i at bits 32i+31:32i |
| engine_ok | output | 1 | Engine health flag, cleared on any failure |
| mb_req | output | 1 | Word access request, held until acknowledged |
| mb_we | output | 1 | Access is a write |
| mb_addr | output | 24 | Word address of the access |
| mb_wdata | output | 32 | Write data |
| mb_ack | input | 1 | Access acknowledge, one cycle |
| mb_err | input | 1 | Transport error, qualified by `mb_ack` |
| mb_rdata | input | 32 | Read data, qualified by `mb_ack` |

## Verification
The completion of one command and the acceptance of the next can fall in the same cycle. The sequencer returns to idle in the very cycle it pulses `done`. To provoke this, the bench raises `start` on the falling edge where it first sees `done` high. It then judges that the second command's fill carries the new command code and completes normally. The opposite case is also covered: a `start` raised while busy, carrying an invalid argument count, must produce neither an extra `done` nor any change to the running exchange.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic [1:0] {
    ST_OK      = 2'd0,
    ST_INVAL   = 2'd1,
    ST_IOERR   = 2'd2,
    ST_TIMEOUT = 2'd3
  } mbx_status_e;

  typedef enum logic [2:0] {
    S_IDLE, S_LOAD, S_GO, S_POLL, S_EVAL, S_CLEAR
  } seq_state_e;

  typedef enum logic [1:0] {
    V_DONE, V_AGAIN, V_RETRY, V_FAIL
  } verdict_e;

  localparam logic [31:0] GO_FLAGS     = 32'h0000_0003;
  localparam logic [31:0] IDLE_FLAGS   = 32'h0000_0000;
  localparam int          ENG_DONE_BIT = 2;
endpackage

// File: rtl/mbx_frame_gen.sv
module mbx_frame_gen #(
  parameter int          WORD_W    = 32,
  parameter int          MAX_ARGS  = 12,
  parameter int          HDR_WORDS = 4,
  parameter int          IDX_W     = 4,
  parameter int          CNT_W     = 4,
  parameter logic [31:0] TMO_WORD  = 32'h0006_0000
) (
  input  logic [IDX_W-1:0]           idx,
  input  logic [WORD_W-1:0]          cmd,
  input  logic [MAX_ARGS*WORD_W-1:0] args,
  input  logic [CNT_W-1:0]           send_cnt,
  output logic [WORD_W-1:0]          word
);
  localparam int SEL_W = $clog2(MAX_ARGS);

  logic [WORD_W-1:0] lane [MAX_ARGS];
  logic [SEL_W-1:0]  arg_sel;

  // Each argument lane is zeroed when it lies past the sent count.
  for (genvar g = 0; g < MAX_ARGS; g++) begin : g_lane
    assign lane[g] = (CNT_W'(g) < send_cnt) ? args[g*WORD_W +: WORD_W] : '0;
  end

  assign arg_sel = SEL_W'(idx - IDX_W'(HDR_WORDS));

  always_comb begin
    word = '0;
    if (idx >= IDX_W'(HDR_WORDS)) word = lane[arg_sel];
    else if (idx == IDX_W'(1))    word = cmd;
    else if (idx == IDX_W'(3))    word = WORD_W'(TMO_WORD);
  end
endmodule

// File: rtl/mbx_retry_ctl.sv
module mbx_retry_ctl
  import mbx_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int POLL_LIMIT = 1000,
  parameter int TRY_LIMIT  = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              try_inc,
  input  logic              poll_inc,
  input  logic [WORD_W-1:0] stat,
  output verdict_e          verdict
);
  localparam int POLL_W = $clog2(POLL_LIMIT + 1);
  localparam int TRY_W  = $clog2(TRY_LIMIT + 1);

  logic [POLL_W-1:0] poll_cnt;
  logic [TRY_W-1:0]  try_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      poll_cnt <= '0;
      try_cnt  <= '0;
    end else if (clr) begin
      poll_cnt <= '0;
      try_cnt  <= TRY_W'(1);
    end else if (try_inc) begin
      poll_cnt <= '0;
      try_cnt  <= try_cnt + TRY_W'(1);
    end else if (poll_inc) begin
      poll_cnt <= poll_cnt + POLL_W'(1);
    end
  end

  always_comb begin
    if (stat[ENG_DONE_BIT])
      verdict = V_DONE;
    else if (stat != '0)
      verdict = (poll_cnt < POLL_W'(POLL_LIMIT)) ? V_AGAIN : V_FAIL;
    else
      verdict = (try_cnt < TRY_W'(TRY_LIMIT)) ? V_RETRY : V_FAIL;
  end

  p_poll_bound_r6: assert property (@(posedge clk) disable iff (rst)
    poll_cnt <= POLL_W'(POLL_LIMIT));
  p_try_bound_r7: assert property (@(posedge clk) disable iff (rst)
    try_cnt <= TRY_W'(TRY_LIMIT));
endmodule

// File: rtl/mbx_result_store.sv
module mbx_result_store #(
  parameter int WORD_W   = 32,
  parameter int MAX_ARGS = 12,
  parameter int SEL_W    = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clr,
  input  logic                       we,
  input  logic [SEL_W-1:0]           sel,
  input  logic [WORD_W-1:0]          wdata,
  output logic [MAX_ARGS*WORD_W-1:0] flat
);
  logic [WORD_W-1:0] slot [MAX_ARGS];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int i = 0; i < MAX_ARGS; i++) slot[i] <= '0;
    end else if (we && (sel < SEL_W'(MAX_ARGS))) begin
      slot[sel] <= wdata;
    end
  end

  for (genvar g = 0; g < MAX_ARGS; g++) begin : g_out
    assign flat[g*WORD_W +: WORD_W] = slot[g];
  end
endmodule

// File: rtl/mbx_cmd_seq.sv
module mbx_cmd_seq
  import mbx_pkg::*;
#(
  parameter int                ADDR_W     = 24,
  parameter int                WORD_W     = 32,
  parameter int                MBOX_WORDS = 16,
  parameter int                HDR_WORDS  = 4,
  parameter logic [ADDR_W-1:0] MBOX_BASE  = 24'h000044,
  parameter int                POLL_LIMIT = 1000,
  parameter int                TRY_LIMIT  = 20,
  parameter logic [31:0]       TMO_WORD   = 32'h0006_0000,
  localparam int MAX_ARGS = MBOX_WORDS - HDR_WORDS,
  localparam int CNT_W    = $clog2(MAX_ARGS + 1),
  localparam int ARG_BITS = MAX_ARGS * WORD_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [WORD_W-1:0]   cmd_code,
  input  logic [CNT_W-1:0]    send_cnt,
  input  logic [CNT_W-1:0]    recv_cnt,
  input  logic [ARG_BITS-1:0] args_in,
  output logic                busy,
  output logic                done,
  output logic [1:0]          status,
  output logic [ARG_BITS-1:0] results,
  output logic                engine_ok,
  output logic                mb_req,
  output logic                mb_we,
  output logic [ADDR_W-1:0]   mb_addr,
  output logic [WORD_W-1:0]   mb_wdata,
  input  logic                mb_ack,
  input  logic                mb_err,
  input  logic [WORD_W-1:0]   mb_rdata
);
  localparam int IDX_W = $clog2(MBOX_WORDS);
  localparam int SEL_W = $clog2(MAX_ARGS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(MBOX_WORDS - 1);

  seq_state_e        state;
  logic [IDX_W-1:0]  idx;
  logic              req_q, we_q, busy_q, done_q, ok_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] wdata_q, cmd_q, stat_q;
  logic [ARG_BITS-1:0] args_q;
  logic [CNT_W-1:0]  send_q, recv_q;
  mbx_status_e       status_q;

  logic              args_ok, accept_go, acc_ok;
  logic              acc_we;
  logic [ADDR_W-1:0] acc_addr;
  logic [WORD_W-1:0] acc_data, frame_word;
  logic [IDX_W-1:0]  poll_last;
  logic              rs_clr, rs_we;
  logic [SEL_W-1:0]  rs_sel;
  logic              rc_poll_inc, rc_try_inc;
  verdict_e          verdict;

  // ---------------- sub-blocks ----------------
  mbx_frame_gen #(
    .WORD_W(WORD_W), .MAX_ARGS(MAX_ARGS), .HDR_WORDS(HDR_WORDS),
    .IDX_W(IDX_W), .CNT_W(CNT_W), .TMO_WORD(TMO_WORD)
  ) u_frame (
    .idx(idx), .cmd(cmd_q), .args(args_q), .send_cnt(send_q), .word(frame_word)
  );

  mbx_retry_ctl #(
    .WORD_W(WORD_W), .POLL_LIMIT(POLL_LIMIT), .TRY_LIMIT(TRY_LIMIT)
  ) u_retry (
    .clk(clk), .rst(rst), .clr(accept_go), .try_inc(rc_try_inc),
    .poll_inc(rc_poll_inc), .stat(stat_q), .verdict(verdict)
  );

  mbx_result_store #(
    .WORD_W(WORD_W), .MAX_ARGS(MAX_ARGS), .SEL_W(SEL_W)
  ) u_store (
    .clk(clk), .rst(rst), .clr(rs_clr), .we(rs_we), .sel(rs_sel),
    .wdata(mb_rdata), .flat(results)
  );

  // ---------------- request qualification ----------------
  assign args_ok   = (send_cnt <= CNT_W'(MAX_ARGS)) && (recv_cnt <= CNT_W'(MAX_ARGS));
  assign accept_go = (state == S_IDLE) && start && args_ok && ok_q;
  assign acc_ok    = req_q && mb_ack && !mb_err;
  assign poll_last = IDX_W'(recv_q) + IDX_W'(HDR_WORDS - 1);

  // ---------------- strobes to sub-blocks ----------------
  assign rs_clr      = (state == S_IDLE) && start;
  assign rs_we       = (state == S_POLL) && acc_ok && (idx >= IDX_W'(HDR_WORDS));
  assign rs_sel      = SEL_W'(idx - IDX_W'(HDR_WORDS));
  assign rc_poll_inc = ((state == S_GO) && acc_ok) ||
                       ((state == S_EVAL) && (verdict == V_AGAIN));
  assign rc_try_inc  = (state == S_EVAL) && (verdict == V_RETRY);

  // ---------------- next access of the current phase ----------------
  always_comb begin
    acc_we   = 1'b0;
    acc_addr = MBOX_BASE;
    acc_data = '0;
    unique case (state)
      S_LOAD: begin
        acc_we   = 1'b1;
        acc_addr = MBOX_BASE + ADDR_W'(idx);
        acc_data = frame_word;
      end
      S_GO: begin
        acc_we   = 1'b1;
        acc_data = WORD_W'(GO_FLAGS);
      end
      S_POLL: begin
        acc_addr = MBOX_BASE + ADDR_W'(idx);
      end
      S_CLEAR: begin
        acc_we   = 1'b1;
        acc_data = WORD_W'(IDLE_FLAGS);
      end
      default: ;
    endcase
  end

  // ---------------- sequencer ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      idx      <= '0;
      req_q    <= 1'b0;
      we_q     <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      ok_q     <= 1'b1;
      status_q <= ST_OK;
      cmd_q    <= '0;
      args_q   <= '0;
      send_q   <= '0;
      recv_q   <= '0;
      stat_q   <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (start) begin
            if (!args_ok) begin
              done_q   <= 1'b1;
              status_q <= ST_INVAL;
            end else if (!ok_q) begin
              done_q   <= 1'b1;
              status_q <= ST_IOERR;
            end else begin
              cmd_q    <= cmd_code;
              args_q   <= args_in;
              send_q   <= send_cnt;
              recv_q   <= recv_cnt;
              busy_q   <= 1'b1;
              idx      <= '0;
              state    <= S_LOAD;
            end
          end
        end

        S_EVAL: begin
          unique case (verdict)
            V_DONE:  state <= S_CLEAR;
            V_AGAIN: begin state <= S_POLL; idx <= '0; end
            V_RETRY: begin state <= S_LOAD; idx <= '0; end
            default: begin
              state    <= S_IDLE;
              busy_q   <= 1'b0;
              done_q   <= 1'b1;
              status_q <= ST_TIMEOUT;
              ok_q     <= 1'b0;
            end
          endcase
        end

        default: begin
          if (!req_q) begin
            req_q   <= 1'b1;
            we_q    <= acc_we;
            addr_q  <= acc_addr;
            wdata_q <= acc_data;
          end else if (mb_ack) begin
            req_q <= 1'b0;
            if (mb_err) begin
              state    <= S_IDLE;
              busy_q   <= 1'b0;
              done_q   <= 1'b1;
              status_q <= ST_IOERR;
              ok_q     <= 1'b0;
            end else begin
              unique case (state)
                S_LOAD: begin
                  if (idx == LAST_IDX) begin
                    idx   <= '0;
                    state <= S_GO;
                  end else begin
                    idx <= idx + IDX_W'(1);
                  end
                end
                S_GO: begin
                  idx   <= '0;
                  state <= S_POLL;
                end
                S_POLL: begin
                  if (idx == '0) stat_q <= mb_rdata;
                  if (idx == poll_last) state <= S_EVAL;
                  else                  idx   <= idx + IDX_W'(1);
                end
                default: begin
                  state    <= S_IDLE;
                  busy_q   <= 1'b0;
                  done_q   <= 1'b1;
                  status_q <= ST_OK;
                end
              endcase
            end
          end
        end
      endcase
    end
  end

  assign busy      = busy_q;
  assign done      = done_q;
  assign status    = status_q;
  assign engine_ok = ok_q;
  assign mb_req    = req_q;
  assign mb_we     = we_q;
  assign mb_addr   = addr_q;
  assign mb_wdata  = wdata_q;

  // ---------------- assertions ----------------
  p_req_held_r3: assert property (@(posedge clk) disable iff (rst)
    mb_req && !mb_ack |=> mb_req && $stable(mb_addr) && $stable(mb_we) && $stable(mb_wdata));
  p_addr_window_r5: assert property (@(posedge clk) disable iff (rst)
    mb_req |-> ((mb_addr - MBOX_BASE) < ADDR_W'(MBOX_WORDS)));
  p_ok_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    !engine_ok |=> !engine_ok);
  p_refused_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !engine_ok |-> !mb_req);
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mb_req);
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_ok_healthy_r8: assert property (@(posedge clk) disable iff (rst)
    done && (status == 2'd0) |-> engine_ok);
endmodule

// File: tb/mbx_cmd_seq_tb.sv
`timescale 1ns/1ps
module mbx_cmd_seq_tb;
  localparam int NA = 12;
  localparam int LOGN = 128;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic          start = 1'b0;
  logic [31:0]   cmd_code = '0;
  logic [3:0]    send_cnt = '0, recv_cnt = '0;
  logic [NA*32-1:0] args_in = '0;
  logic          busy, done, engine_ok, mb_req, mb_we;
  logic [1:0]    status;
  logic [NA*32-1:0] results;
  logic [23:0]   mb_addr;
  logic [31:0]   mb_wdata;
  logic          mb_ack, mb_err;
  logic [31:0]   mb_rdata;

  mbx_cmd_seq u_dut (
    .clk(clk), .rst(rst), .start(start), .cmd_code(cmd_code),
    .send_cnt(send_cnt), .recv_cnt(recv_cnt), .args_in(args_in),
    .busy(busy), .done(done), .status(status), .results(results),
    .engine_ok(engine_ok), .mb_req(mb_req), .mb_we(mb_we),
    .mb_addr(mb_addr), .mb_wdata(mb_wdata), .mb_ack(mb_ack),
    .mb_err(mb_err), .mb_rdata(mb_rdata)
  );

  int checks = 0;
  int failures = 0;

  // ---------------- remote engine model ----------------
  logic [31:0] mem [16];
  int acc_n, err_at, attempts, polls, mode, done_after, zero_tries;
  logic        lg_we   [LOGN];
  logic [23:0] lg_addr [LOGN];
  logic [31:0] lg_data [LOGN];
  integer a;

  function automatic logic [31:0] flag_word();
    case (mode)
      0: return (polls >= done_after) ? 32'h7 : 32'h3;
      1: return (attempts <= zero_tries) ? 32'h0 : 32'h7;
      2: return 32'h3;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mb_ack <= 1'b0; mb_err <= 1'b0; mb_rdata <= '0;
    end else if (mb_req && !mb_ack) begin
      acc_n = acc_n + 1;
      a = int'(mb_addr) - 'h44;
      mb_ack <= 1'b1;
      mb_err <= (acc_n == err_at);
      if (acc_n <= LOGN) begin
        lg_we[acc_n-1] = mb_we; lg_addr[acc_n-1] = mb_addr; lg_data[acc_n-1] = mb_wdata;
      end
      if (mb_we) begin
        if (a >= 0 && a < 16) mem[a] = mb_wdata;
        if (a == 0 && mb_wdata == 32'h3) begin
          attempts = attempts + 1; polls = 0;
          for (int i = 0; i < NA; i++) mem[4+i] = 32'hBEEF_0000 + mem[1] + i*17;
        end
      end else begin
        if (a == 0) begin polls = polls + 1; mb_rdata <= flag_word(); end
        else if (a > 0 && a < 16) mb_rdata <= mem[a];
        else mb_rdata <= 32'hDEAD_DEAD;
      end
    end else begin
      mb_ack <= 1'b0; mb_err <= 1'b0;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic clr_model(input int m, input int da, input int zt, input int ea);
    acc_n = 0; attempts = 0; polls = 0; mode = m; done_after = da; zero_tries = zt; err_at = ea;
    for (int i = 0; i < 16; i++) mem[i] = 32'h5555_5555;
  endtask

  task automatic do_reset();
    rst = 1'b1; start = 1'b0;
    clr_model(0, 1, 0, 0);
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  function automatic logic [31:0] arg_val(input logic [31:0] c, input int i);
    return 32'hA000_0000 + c*16 + i;
  endfunction

  task automatic drive(input logic [31:0] c, input int s, input int r);
    cmd_code = c; send_cnt = 4'(s); recv_cnt = 4'(r);
    for (int i = 0; i < NA; i++) args_in[i*32 +: 32] = arg_val(c, i);
  endtask

  task automatic issue(input logic [31:0] c, input int s, input int r);
    @(negedge clk);
    drive(c, s, r);
    start = 1'b1;
    @(posedge clk);
    #1 start = 1'b0;
  endtask

  task automatic wait_done(input string req);
    bit got = 0;
    for (int k = 0; k < 40000 && !got; k++) begin
      @(negedge clk);
      if (done) got = 1;
    end
    chk(req, "done seen", got, 1);
  endtask

  task automatic chk_results(input string req, input logic [31:0] c, input int r);
    for (int i = 0; i < NA; i++)
      chk(req, $sformatf("result %0d", i), results[i*32 +: 32],
          (i < r) ? 32'hBEEF_0000 + c + i*17 : 32'h0);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    do_reset();
    @(negedge clk);
    chk("R1", "busy", busy, 0);
    chk("R1", "done", done, 0);
    chk("R1", "mb_req", mb_req, 0);
    chk("R1", "status", status, 0);
    chk("R1", "engine_ok", engine_ok, 1);
  endtask

  task automatic t_basic();
    logic [31:0] c = 32'h5A;
    clr_model(0, 1, 0, 0);
    issue(c, 3, 2);
    wait_done("R8");
    chk("R8", "status", status, 0);
    chk("R5", "access count", acc_n, 24);
    for (int i = 0; i < 16; i++) begin
      logic [31:0] e;
      e = (i == 1) ? c : (i == 3) ? 32'h0006_0000 :
          (i >= 4 && i < 7) ? arg_val(c, i-4) : 32'h0;
      chk("R3", $sformatf("fill %0d", i), {lg_we[i], lg_addr[i], lg_data[i]}, {1'b1, 24'h44 + 24'(i), e});
    end
    chk("R4", "go write", {lg_we[16], lg_addr[16], lg_data[16]}, {1'b1, 24'h44, 32'h3});
    for (int j = 0; j < 6; j++)
      chk("R5", $sformatf("poll read %0d", j), {lg_we[17+j], lg_addr[17+j]}, {1'b0, 24'h44 + 24'(j)});
    chk("R8", "idle write", {lg_we[23], lg_addr[23], lg_data[23]}, {1'b1, 24'h44, 32'h0});
    chk_results("R8", c, 2);
    @(negedge clk);
    chk("R12", "done drops", done, 0);
    chk("R12", "status held", status, 0);
    chk("R12", "result held", results[31:0], 32'hBEEF_0000 + c);
  endtask

  task automatic t_slow_full();
    logic [31:0] c = 32'h21;
    clr_model(0, 5, 0, 0);
    issue(c, 12, 12);
    wait_done("R6");
    chk("R6", "status", status, 0);
    chk("R6", "access count with 5 polls", acc_n, 16 + 1 + 5*16 + 1);
    chk("R3", "last arg word", lg_data[15], arg_val(c, 11));
    chk_results("R5", c, 12);
  endtask

  task automatic t_zero_counts();
    clr_model(0, 2, 0, 0);
    issue(32'h33, 0, 0);
    wait_done("R3");
    chk("R5", "access count", acc_n, 16 + 1 + 8 + 1);
    for (int i = 4; i < 16; i++) chk("R3", "unused arg zero", lg_data[i], 0);
    chk_results("R8", 32'h33, 0);
  endtask

  task automatic t_reject();
    clr_model(0, 1, 0, 0);
    issue(32'h1, 13, 0);
    wait_done("R2");
    chk("R2", "status send", status, 1);
    chk("R2", "no access", acc_n, 0);
    issue(32'h1, 0, 15);
    wait_done("R2");
    chk("R2", "status recv", status, 1);
    chk("R2", "no access", acc_n, 0);
  endtask

  task automatic t_retry_ok();
    clr_model(1, 1, 3, 0);
    issue(32'h44, 2, 1);
    wait_done("R7");
    chk("R7", "status", status, 0);
    chk("R7", "attempts", attempts, 4);
    chk("R7", "access count", acc_n, 3*22 + 23);
    chk_results("R7", 32'h44, 1);
  endtask

  task automatic t_overlap();
    int n0;
    clr_model(0, 3, 0, 0);
    issue(32'h61, 1, 1);
    repeat (10) @(negedge clk);
    drive(32'h62, 13, 0);
    start = 1'b1;
    @(posedge clk);
    #1 start = 1'b0;
    wait_done("R11");
    chk("R11", "status of first", status, 0);
    chk("R11", "cmd word of first", lg_data[1], 32'h61);
    n0 = acc_n;
    chk("R11", "access count", n0, 16 + 1 + 3*5 + 1);
    // start in the very cycle done is high
    drive(32'h63, 0, 0);
    start = 1'b1;
    @(posedge clk);
    #1 start = 1'b0;
    @(negedge clk);
    chk("R11", "busy after back-to-back start", busy, 1);
    wait_done("R11");
    chk("R11", "second status", status, 0);
    chk("R11", "second cmd word", lg_data[n0 + 1], 32'h63);
  endtask

  task automatic t_stuck();
    do_reset();
    clr_model(2, 1, 0, 0);
    issue(32'h70, 0, 0);
    wait_done("R6");
    chk("R6", "status timeout", status, 3);
    chk("R6", "engine_ok cleared", engine_ok, 0);
    chk("R6", "1000 polls", acc_n, 17 + 1000*4);
    clr_model(0, 1, 0, 0);
    issue(32'h71, 1, 1);
    wait_done("R10");
    chk("R10", "refused status", status, 2);
    chk("R10", "no access", acc_n, 0);
    issue(32'h72, 13, 0);
    wait_done("R2");
    chk("R2", "limit check first", status, 1);
    do_reset();
    @(negedge clk);
    chk("R1", "engine_ok restored", engine_ok, 1);
  endtask

  task automatic t_all_zero();
    do_reset();
    clr_model(3, 1, 0, 0);
    issue(32'h80, 0, 2);
    wait_done("R7");
    chk("R7", "status timeout", status, 3);
    chk("R7", "attempts", attempts, 20);
    chk("R7", "access count", acc_n, 20*23);
    chk("R7", "engine_ok cleared", engine_ok, 0);
  endtask

  task automatic t_err();
    do_reset();
    clr_model(0, 1, 0, 17);
    issue(32'h90, 0, 0);
    wait_done("R9");
    chk("R9", "status io", status, 2);
    chk("R9", "stopped at error", acc_n, 17);
    chk("R9", "engine_ok cleared", engine_ok, 0);
    repeat (5) @(negedge clk);
    chk("R9", "stays cleared", engine_ok, 0);
    do_reset();
    clr_model(0, 1, 0, 19);
    issue(32'h91, 0, 0);
    wait_done("R9");
    chk("R9", "poll error status", status, 2);
    chk("R9", "poll error count", acc_n, 19);
    do_reset();
  endtask

  initial begin
    t_reset();
    t_basic();
    t_slow_full();
    t_zero_counts();
    t_reject();
    t_retry_ok();
    t_overlap();
    t_stuck();
    t_all_zero();
    t_err();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule